// File: doc/BRIEF.md
# Masked Vector Shift Unit

This block shifts every element of a sixteen-element vector of 32-bit integers in one operation. It offers three shift kinds: logical left, logical right and arithmetic right. The shift count comes from one of two places. An 8-bit immediate can supply a single count for all lanes. Otherwise each lane reads its own 32-bit count from the matching element of a count vector.

A count too large for the element width does not wrap. Logical shifts then give zero, and the arithmetic shift gives a full copy of the sign bit. A 16-bit write mask decides which lanes take the shifted value and which keep the old destination value. The merged vector is registered, and a valid pulse marks the cycle after a start strobe.

Top module: `vshift_unit`

## Requirements
- R1: With operation code 0 (logical left), each 32-bit element is shifted left by its count, and zeros enter from bit 0; each lane is independent of the others.
- R2: With operation code 1 (logical right), each element is shifted right, and zeros enter the vacated high bits.
- R3: With operation code 2 (arithmetic right), each element is shifted right, and bit 31 of the source element is copied into the vacated high bits.
- R4: For codes 0 and 1, a count of 32 or more gives an all-zero element; the count is never reduced modulo 32.
- R5: For code 2, a count of 32 or more gives an element whose every bit equals the source sign bit.
- R6: When `cnt_var` is 1, lane i uses the unsigned 32-bit value in bits [32i+31:32i] of `cnt_vec`. When `cnt_var` is 0, every lane uses `imm_cnt`, zero-extended.
- R7: A lane whose bit in `wr_mask` is 0 outputs the matching element of `old_dst`. Bit i of the mask governs lane i.
- R8: Operation code 3 outputs `old_dst` unchanged in every lane, whatever the mask.
- R9: `res_vec` and `res_valid` update on the clock edge that samples `start` high, and `res_valid` is 1 for exactly that one cycle. Without `start`, `res_vec` holds its value.
- R10: While `rst_n` is low at a clock edge, `res_valid` and `res_vec` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe; operands are sampled on this edge |
| op_sel | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 pass old destination |
| cnt_var | input | 1 | 1 selects per-lane counts, 0 selects the immediate |
| imm_cnt | input | 8 | Shared shift count |
| src_vec | input | 512 | Source elements, lane i at bits [32i+31:32i] |
| cnt_vec | input | 512 | Per-lane shift counts |
| wr_mask | input | 16 | Lane write enables |
| old_dst | input | 512 | Prior destination contents |
| res_vec | output | 512 | Registered merged result |
| res_valid | output | 1 | One-cycle result strobe |

## Verification
The bench targets the count boundaries 31, 32, 255 and large 32-bit counts whose low five bits are small. A design that masked the count to five bits would return a shifted value instead of zero or a sign fill in those cases. Negative lanes under arithmetic shift catch a design that fills with zeros. Sparse masks and operation code 3 expose lanes that were written when they should have been kept. Holding `start` low after a result catches a design whose valid flag sticks, or whose result register keeps loading.

// File: rtl/vshift_pkg.sv
// Shared parameters and the operation encoding for the vector shift unit.
package vshift_pkg;
    localparam int LANES   = 16;
    localparam int ELEM_W  = 32;
    localparam int IMM_W   = 8;
    localparam int AMT_W   = $clog2(ELEM_W);

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_KEEP  = 2'd3
    } shift_op_e;
endpackage

// File: rtl/vshift_count_sel.sv
// Chooses the count for one lane: either the shared immediate (zero-extended)
// or the lane's own element of the count vector. Assumes IMM_W <= ELEM_W.
module vshift_count_sel #(
    parameter int ELEM_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              use_var,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ELEM_W-1:0] lane_cnt,
    output logic [ELEM_W-1:0] cnt
);
    // pick the count source
    always_comb begin
        if (use_var) cnt = lane_cnt;
        else         cnt = {{(ELEM_W-IMM_W){1'b0}}, imm};
    end
endmodule

// File: rtl/vshift_lane.sv
// One lane: shift by an unsigned count that saturates at ELEM_W or more,
// then merge with the old value under the lane's mask bit.
// Assumes ELEM_W is a power of two.
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  shift_op_e         op,
    input  logic [ELEM_W-1:0] src,
    input  logic [ELEM_W-1:0] cnt,
    input  logic              en,
    input  logic [ELEM_W-1:0] old,
    output logic [ELEM_W-1:0] res
);
    localparam int AW = $clog2(ELEM_W);

    logic              over;
    logic [AW-1:0]     amt;
    logic [ELEM_W-1:0] shifted;

    // split count into in-range amount and overflow flag
    always_comb begin
        over = |cnt[ELEM_W-1:AW];
        amt  = cnt[AW-1:0];
    end

    // compute the shifted element, with saturation
    always_comb begin
        case (op)
            SH_LEFT:  shifted = over ? '0 : (src << amt);
            SH_RIGHT: shifted = over ? '0 : (src >> amt);
            SH_ARITH: shifted = over ? {ELEM_W{src[ELEM_W-1]}}
                                     : $unsigned($signed(src) >>> amt);
            default:  shifted = old;
        endcase
    end

    // merge under the write enable; the keep code always passes old
    always_comb begin
        if (en && op != SH_KEEP) res = shifted;
        else                     res = old;
    end
endmodule

// File: rtl/vshift_unit.sv
// Top of the masked vector shift unit. Operands are sampled on the edge
// where start is high; the merged result and a one-cycle valid appear
// after that edge. Assumes all vector inputs are stable around that edge.
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int N_LANE = LANES,
    parameter int EW     = ELEM_W,
    parameter int IW     = IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op_sel,
    input  logic               cnt_var,
    input  logic [IW-1:0]      imm_cnt,
    input  logic [N_LANE*EW-1:0] src_vec,
    input  logic [N_LANE*EW-1:0] cnt_vec,
    input  logic [N_LANE-1:0]  wr_mask,
    input  logic [N_LANE*EW-1:0] old_dst,
    output logic [N_LANE*EW-1:0] res_vec,
    output logic               res_valid
);
    localparam int VW = N_LANE * EW;

    shift_op_e     op;
    logic [VW-1:0] lane_cnt;
    logic [VW-1:0] merged;

    // decode the operation code
    always_comb op = shift_op_e'(op_sel);

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        vshift_count_sel #(.ELEM_W(EW), .IMM_W(IW)) u_cnt (
            .use_var  (cnt_var),
            .imm      (imm_cnt),
            .lane_cnt (cnt_vec[g*EW +: EW]),
            .cnt      (lane_cnt[g*EW +: EW])
        );
        vshift_lane #(.ELEM_W(EW)) u_sh (
            .op  (op),
            .src (src_vec[g*EW +: EW]),
            .cnt (lane_cnt[g*EW +: EW]),
            .en  (wr_mask[g]),
            .old (old_dst[g*EW +: EW]),
            .res (merged[g*EW +: EW])
        );
    end

    // capture the merged vector on start
    always_ff @(posedge clk) begin
        if (!rst_n)     res_vec <= '0;
        else if (start) res_vec <= merged;
    end

    // valid pulses once per start
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= start;
    end
endmodule

// File: rtl/vshift_unit_chk.sv
// Property checker for vshift_unit, attached by bind below.
module vshift_unit_chk #(
    parameter int N_LANE = 16,
    parameter int EW     = 32,
    parameter int IW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [1:0]           op_sel,
    input logic                 cnt_var,
    input logic [IW-1:0]        imm_cnt,
    input logic [N_LANE*EW-1:0] old_dst,
    input logic [N_LANE-1:0]    wr_mask,
    input logic [N_LANE*EW-1:0] res_vec,
    input logic                 res_valid
);
    // R9
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    // R9
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(res_vec));
    // R8
    keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel == 2'd3) |=> res_vec == $past(old_dst));
    // R7
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wr_mask == '0) |=> res_vec == $past(old_dst));
    // R4
    logical_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel != 2'd2 && op_sel != 2'd3 && !cnt_var
         && imm_cnt >= IW'(EW) && wr_mask == '1) |=> res_vec == '0);
endmodule

bind vshift_unit vshift_unit_chk #(.N_LANE(N_LANE), .EW(EW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .cnt_var(cnt_var), .imm_cnt(imm_cnt), .old_dst(old_dst),
    .wr_mask(wr_mask), .res_vec(res_vec), .res_valid(res_valid)
);

// File: tb/sim_vshift_unit.sv
module sim_vshift_unit;
    localparam int NL = 16;
    localparam int EW = 32;
    localparam int VW = NL * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_sel = 2'd0;
    logic          cnt_var = 1'b0;
    logic [7:0]    imm_cnt = 8'd0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] cnt_vec = '0;
    logic [NL-1:0] wr_mask = '0;
    logic [VW-1:0] old_dst = '0;
    logic [VW-1:0] res_vec;
    logic          res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vshift_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .cnt_var(cnt_var), .imm_cnt(imm_cnt), .src_vec(src_vec),
        .cnt_vec(cnt_vec), .wr_mask(wr_mask), .old_dst(old_dst),
        .res_vec(res_vec), .res_valid(res_valid)
    );

    // case word: {op[2], var[1], imm[8], mask[16], pattern[2], tag[4]}
    localparam logic [32:0] CASES [14] = '{
        {2'd0, 1'b0, 8'd4,   16'hFFFF, 2'd0, 4'd1},
        {2'd0, 1'b0, 8'd0,   16'hFFFF, 2'd0, 4'd1},
        {2'd1, 1'b0, 8'd31,  16'hFFFF, 2'd0, 4'd2},
        {2'd2, 1'b0, 8'd7,   16'hFFFF, 2'd0, 4'd3},
        {2'd1, 1'b0, 8'd32,  16'hFFFF, 2'd0, 4'd4},
        {2'd0, 1'b0, 8'd255, 16'hFFFF, 2'd0, 4'd4},
        {2'd2, 1'b0, 8'd200, 16'hFFFF, 2'd0, 4'd5},
        {2'd0, 1'b1, 8'd0,   16'hFFFF, 2'd0, 4'd6},
        {2'd1, 1'b1, 8'd0,   16'hFFFF, 2'd1, 4'd4},
        {2'd2, 1'b1, 8'd0,   16'hFFFF, 2'd3, 4'd5},
        {2'd2, 1'b1, 8'd3,   16'h5A3C, 2'd2, 4'd7},
        {2'd0, 1'b0, 8'd9,   16'h0000, 2'd0, 4'd7},
        {2'd3, 1'b0, 8'd3,   16'hFFFF, 2'd0, 4'd8},
        {2'd1, 1'b1, 8'd0,   16'hFFFF, 2'd3, 4'd2}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] src_el(input int i);
        logic [31:0] b;
        b = i[0] ? 32'hF0F0_0F0F : 32'h0F0F_F0F0;
        return b ^ (32'(i) << 8);
    endfunction

    function automatic logic [31:0] cnt_el(input logic [1:0] p, input int i);
        case (p)
            2'd0: return 32'(i * 3);
            2'd1: return 32'h100 + 32'(i);
            2'd2: return i[0] ? 32'hFFFF_FFFF : 32'(i);
            default: return 32'd31 + 32'(i % 4);
        endcase
    endfunction

    // bit-at-a-time reference shift
    function automatic logic [31:0] ref_el(input logic [1:0] op,
                                           input logic [31:0] s,
                                           input logic [31:0] c);
        logic [31:0] v = s;
        for (int k = 0; k < 40; k++) begin
            if (32'(k) < c) begin
                case (op)
                    2'd0: v = {v[30:0], 1'b0};
                    2'd1: v = {1'b0, v[31:1]};
                    default: v = {s[31], v[31:1]};
                endcase
            end
        end
        return v;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic launch;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] exp;
        logic [VW-1:0] prev;
        for (int i = 0; i < NL; i++) old_dst[i*EW +: EW] = 32'hDEAD_0000 | 32'(i);
        src_vec = '1; start = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs even with start high
        check("R10", "reset result", res_vec, '0);
        check("R10", "reset valid", VW'(res_valid), '0);
        start = 1'b0;
        rst_n = 1'b1;

        foreach (CASES[n]) begin
            logic [32:0] c = CASES[n];
            op_sel = c[32:31]; cnt_var = c[30]; imm_cnt = c[29:22];
            wr_mask = c[21:6];
            for (int i = 0; i < NL; i++) begin
                logic [31:0] cc;
                src_vec[i*EW +: EW] = src_el(i);
                cnt_vec[i*EW +: EW] = cnt_el(c[5:4], i);
                cc = c[30] ? cnt_el(c[5:4], i) : {24'd0, c[29:22]};
                if (c[32:31] == 2'd3 || !c[6+i])
                    exp[i*EW +: EW] = old_dst[i*EW +: EW];
                else
                    exp[i*EW +: EW] = ref_el(c[32:31], src_el(i), cc);
            end
            launch();
            check(tag_name(c[3:0]), $sformatf("case %0d", n), res_vec, exp);
            check("R9", "valid after start", VW'(res_valid), VW'(1));
        end

        // R9: valid drops and result holds without start
        prev = res_vec;
        src_vec = '0; op_sel = 2'd0; wr_mask = '1;
        @(negedge clk);
        check("R9", "valid low", VW'(res_valid), '0);
        check("R9", "result held", res_vec, prev);

        // R8: keep code with empty mask still gives old
        op_sel = 2'd3; wr_mask = '0; launch();
        check("R8", "keep code empty mask", res_vec, old_dst);

        // R3: most-negative element, count 31
        op_sel = 2'd2; cnt_var = 1'b0; imm_cnt = 8'd31; wr_mask = '1;
        src_vec = {NL{32'h8000_0000}};
        launch();
        check("R3", "sign fill at 31", res_vec, '1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule